// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block is a register-mapped general-purpose I/O controller organised as banks of 32 pins. Each bank holds an output latch, a direction register and an output-enable register, and a read-only view of the pin levels taken through a two-flop synchronizer. Software reaches all of them over a simple 32-bit bus. A write is committed on the clock edge where the strobe is high. A read returns data combinationally for the address currently on the bus.

Each 16-bit half of a bank's output latch also has a write-only masked port. A single write can set or clear chosen output bits while the other bits keep their values, so no read-modify-write sequence is needed. A pin is driven only when it is configured as an output and its output enable is also set. A pin that is configured as an output with the enable clear stays tristated. Some pins are not implemented, and a per-bank mask parameter removes them. With the default mask, bank 1 holds only 22 pins.

Top module: `gpio_banked`

## Requirements
- R1: After reset, every output latch, direction register and output-enable register reads 0, and `pin_out_o` and `pin_oe_o` are all 0.
- R2: The output latch of bank b is read and written at offset 0x40+4*b. A read returns the latch value, so reading it, XOR-ing a bit and writing the result back toggles that pin on `pin_out_o`.
- R3: A write to offset 8*b updates bits 15:0 of bank b's latch. Bits 31:16 of the written word are a mask and bits 15:0 are data. A mask bit of 0 loads the matching latch bit from data, a mask bit of 1 keeps it, and latch bits 31:16 do not change. This port reads as 0.
- R4: A write to offset 8*b+4 updates bits 31:16 of bank b's latch, with the same mask and data layout as R3. Latch bits 15:0 do not change. This port reads as 0.
- R5: Offset 0x60+4*b returns bank b's pin levels, whatever the direction settings. A change on `pin_in_i` becomes visible after exactly two rising clock edges. Writes to this offset have no effect.
- R6: The direction register of bank b sits at 0x204+0x40*b, where 1 means output. The output-enable register sits at 0x208+0x40*b. Both can be read back.
- R7: `pin_oe_o` for a pin is 1 only when both its direction bit and its enable bit are 1. A pin set as an output with enable 0 is tristated. `pin_out_o` always shows the output latch.
- R8: Unimplemented bits read as 0 in every register, ignore writes, and never assert `pin_out_o` or `pin_oe_o`. With the default mask these are bits 31:22 of bank 1.
- R9: A write to an undefined offset changes no register, and a read from an undefined offset returns 0.
- R10: A write takes effect at the rising edge where `we_i` is 1. A read of the same register during that cycle still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | ADDR_W (12) | Byte offset of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_in_i | input | NUM_BANKS*32 (128) | Pin levels, asynchronous |
| pin_out_o | output | NUM_BANKS*32 (128) | Output latch value per pin |
| pin_oe_o | output | NUM_BANKS*32 (128) | Drive enable per pin |

## Verification
The bench targets the masked ports from both sides. A design that swapped the sense of the mask, or let a low-half write leak into the high half, would corrupt bits that the write was meant to keep. It checks the tristate case, where direction is output and the enable is clear; a design that drove from the direction bit alone would raise `pin_oe_o` there. It counts the input latency edge by edge, so one synchronizer stage too few or too many shows up. It also writes all ones into bank 1 and to undefined offsets, which exposes registers that keep bits above pin 21 or that decode addresses loosely.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int BANK_W  = 32;
  localparam int HALF_W  = 16;

  // register map
  localparam int MLO_BASE    = 'h000;
  localparam int MSK_STRIDE  = 8;
  localparam int MHI_OFF     = 4;
  localparam int DATA_BASE   = 'h040;
  localparam int RO_BASE     = 'h060;
  localparam int WORD_STRIDE = 4;
  localparam int DIR_BASE    = 'h204;
  localparam int OE_BASE     = 'h208;
  localparam int CTRL_STRIDE = 'h40;

  typedef struct packed {
    logic [BANK_W-1:0] out_q;
    logic [BANK_W-1:0] dir_q;
    logic [BANK_W-1:0] oe_q;
    logic [BANK_W-1:0] in_q;
  } bank_regs_t;

  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] old_v,
    input logic [BANK_W-1:0] wr_v
  );
    return (old_v & wr_v[BANK_W-1:HALF_W]) | (wr_v[HALF_W-1:0] & ~wr_v[BANK_W-1:HALF_W]);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_pkg::*;
#(
  parameter logic [BANK_W-1:0] IMPL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic              we_mlo_i,
  input  logic              we_mhi_i,
  input  logic              we_data_i,
  input  logic              we_dir_i,
  input  logic              we_oe_i,
  input  logic [BANK_W-1:0] pin_in_i,
  output bank_regs_t        regs_o,
  output logic [BANK_W-1:0] pin_out_o,
  output logic [BANK_W-1:0] pin_oe_o
);
  logic [BANK_W-1:0] out_q, dir_q, oe_q, sync_q;
  logic [1:0]        warm_q;

  gpio_sync #(.WIDTH(BANK_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
    end else if (we_data_i) begin
      out_q <= wdata_i & IMPL;
    end else if (we_mlo_i) begin
      out_q[HALF_W-1:0] <= masked_merge(out_q[HALF_W-1:0], wdata_i) & IMPL[HALF_W-1:0];
    end else if (we_mhi_i) begin
      out_q[BANK_W-1:HALF_W] <= masked_merge(out_q[BANK_W-1:HALF_W], wdata_i) & IMPL[BANK_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      oe_q  <= '0;
    end else begin
      if (we_dir_i) dir_q <= wdata_i & IMPL;
      if (we_oe_i)  oe_q  <= wdata_i & IMPL;
    end
  end

  // marks two clean edges since reset, for the latency check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else         warm_q <= {warm_q[0], 1'b1};
  end

  assign regs_o.out_q = out_q;
  assign regs_o.dir_q = dir_q;
  assign regs_o.oe_q  = oe_q;
  assign regs_o.in_q  = sync_q & IMPL;
  assign pin_out_o    = out_q;
  assign pin_oe_o     = dir_q & oe_q;

  AST_MLO_KEEPS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_mlo_i |=> out_q[BANK_W-1:HALF_W] == $past(out_q[BANK_W-1:HALF_W])); // R3
  AST_MLO_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_mlo_i |=> ((out_q[HALF_W-1:0] ^ $past(wdata_i[HALF_W-1:0])) & ~$past(wdata_i[BANK_W-1:HALF_W]) & IMPL[HALF_W-1:0]) == '0); // R3
  AST_MHI_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_mhi_i |=> out_q[HALF_W-1:0] == $past(out_q[HALF_W-1:0])); // R4
  AST_SYNC_TWO_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q[1] |-> regs_o.in_q == ($past(pin_in_i, 2) & IMPL)); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_mlo_i || we_mhi_i || we_data_i || we_dir_i || we_oe_i)
      |=> $stable(out_q) && $stable(dir_q) && $stable(oe_q)); // R9
  AST_TRISTATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_oe_i && wdata_i == '0) |=> pin_oe_o == '0); // R7
  AST_UNIMPL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o | pin_out_o | regs_o.in_q) & ~IMPL) == '0); // R8
endmodule

// File: rtl/gpio_banked.sv
`timescale 1ns/1ps
module gpio_banked
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter logic [NUM_BANKS*BANK_W-1:0] IMPL_MASK =
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h003F_FFFF, 32'hFFFF_FFFF}
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [BANK_W-1:0]           rdata_o,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_in_i,
  output logic [NUM_BANKS*BANK_W-1:0] pin_out_o,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe_o
);
  localparam int PINS = NUM_BANKS * BANK_W;

  logic [NUM_BANKS-1:0] bank_hit;
  logic [BANK_W-1:0]    bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_MLO  = ADDR_W'(MLO_BASE + MSK_STRIDE * b);
    localparam logic [ADDR_W-1:0] A_MHI  = ADDR_W'(MLO_BASE + MSK_STRIDE * b + MHI_OFF);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_BASE + WORD_STRIDE * b);
    localparam logic [ADDR_W-1:0] A_RO   = ADDR_W'(RO_BASE + WORD_STRIDE * b);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_BASE + CTRL_STRIDE * b);
    localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(OE_BASE + CTRL_STRIDE * b);

    logic       sel_mlo, sel_mhi, sel_data, sel_ro, sel_dir, sel_oe;
    bank_regs_t regs;

    assign sel_mlo  = addr_i == A_MLO;
    assign sel_mhi  = addr_i == A_MHI;
    assign sel_data = addr_i == A_DATA;
    assign sel_ro   = addr_i == A_RO;
    assign sel_dir  = addr_i == A_DIR;
    assign sel_oe   = addr_i == A_OE;

    gpio_bank #(.IMPL(IMPL_MASK[b*BANK_W +: BANK_W])) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wdata_i  (wdata_i),
      .we_mlo_i (we_i && sel_mlo),
      .we_mhi_i (we_i && sel_mhi),
      .we_data_i(we_i && sel_data),
      .we_dir_i (we_i && sel_dir),
      .we_oe_i  (we_i && sel_oe),
      .pin_in_i (pin_in_i[b*BANK_W +: BANK_W]),
      .regs_o   (regs),
      .pin_out_o(pin_out_o[b*BANK_W +: BANK_W]),
      .pin_oe_o (pin_oe_o[b*BANK_W +: BANK_W])
    );

    assign bank_hit[b] = sel_mlo | sel_mhi | sel_data | sel_ro | sel_dir | sel_oe;
    // masked ports are write-only and fall through to zero
    assign bank_rd[b]  = ({BANK_W{sel_data}} & regs.out_q)
                       | ({BANK_W{sel_ro}}   & regs.in_q)
                       | ({BANK_W{sel_dir}}  & regs.dir_q)
                       | ({BANK_W{sel_oe}}   & regs.oe_q);
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdata_o |= bank_rd[b];
  end

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_hit == '0) |-> rdata_o == '0); // R9
  AST_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit)); // R9
  AST_OE_NEEDS_OUT_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o & ~IMPL_MASK) == PINS'(0))); // R8
endmodule

// File: tb/gpio_banked_tb_top.sv
`timescale 1ns/1ps
module gpio_banked_tb_top;
  localparam int NB = 4;
  localparam int W  = 32;
  localparam logic [W-1:0] IMPL [NB] = '{32'hFFFF_FFFF, 32'h003F_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [11:0]       addr_i = '0;
  logic [W-1:0]      wdata_i = '0;
  logic [W-1:0]      rdata_o;
  logic [NB*W-1:0]   pin_in_i = '0;
  logic [NB*W-1:0]   pin_out_o;
  logic [NB*W-1:0]   pin_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_banked dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_in_i(pin_in_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
  );

  function automatic logic [11:0] a_data(int b); return 12'(64 + 4*b); endfunction
  function automatic logic [11:0] a_ro(int b);   return 12'(96 + 4*b); endfunction
  function automatic logic [11:0] a_dir(int b);  return 12'(516 + 64*b); endfunction
  function automatic logic [11:0] a_oe(int b);   return 12'(520 + 64*b); endfunction
  function automatic logic [11:0] a_mlo(int b);  return 12'(8*b); endfunction
  function automatic logic [11:0] a_mhi(int b);  return 12'(8*b + 4); endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [W-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [W-1:0] v);
    @(negedge clk_i);
    addr_i = a;
    #0.5 v = rdata_o;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    for (int b = 0; b < NB; b++) begin
      rd(a_data(b), v); chk("R1 data", 128'(v), 0);
      rd(a_dir(b), v);  chk("R1 dir", 128'(v), 0);
      rd(a_oe(b), v);   chk("R1 oe", 128'(v), 0);
    end
    chk("R1 pin_out", pin_out_o, 0);
    chk("R1 pin_oe", pin_oe_o, 0);
  endtask

  task automatic t_data_toggle();
    logic [W-1:0] v;
    wr(a_data(0), 32'hA5A5_1234);
    rd(a_data(0), v); chk("R2 readback", 128'(v), 128'(32'hA5A5_1234));
    wr(a_data(3), 32'h0000_00F0);
    rd(a_data(3), v);
    wr(a_data(3), v ^ 32'h8000_0001);
    rd(a_data(3), v); chk("R2 toggle", 128'(v), 128'(32'h8000_00F1));
    #0.1 chk("R2 pin_out bank3", 128'(pin_out_o[127:96]), 128'(32'h8000_00F1));
  endtask

  task automatic t_masked();
    logic [W-1:0] v;
    wr(a_data(2), 32'hFFFF_0000);
    wr(a_mlo(2), {16'hFF00, 16'h00AB});
    rd(a_data(2), v); chk("R3 low load", 128'(v), 128'(32'hFFFF_00AB));
    wr(a_mlo(2), {16'h00FF, 16'hFFFF});
    rd(a_data(2), v); chk("R3 low keep", 128'(v), 128'(32'hFFFF_FFAB));
    rd(a_mlo(2), v); chk("R3 port reads zero", 128'(v), 0);
    wr(a_mhi(2), {16'h0F0F, 16'h0000});
    rd(a_data(2), v); chk("R4 high clear", 128'(v), 128'(32'h0F0F_FFAB));
    wr(a_mhi(0), {16'hFFFE, 16'h0000});
    rd(a_data(0), v); chk("R4 single bit", 128'(v), 128'(32'hA5A4_1234));
    rd(a_mhi(0), v); chk("R4 port reads zero", 128'(v), 0);
  endtask

  task automatic t_dir_oe();
    logic [W-1:0] v;
    wr(a_dir(2), 32'hF0F0_F0F0);
    wr(a_oe(2), 32'hFF00_FF00);
    rd(a_dir(2), v); chk("R6 dir", 128'(v), 128'(32'hF0F0_F0F0));
    rd(a_oe(2), v);  chk("R6 oe", 128'(v), 128'(32'hFF00_FF00));
    chk("R7 tristate and", 128'(pin_oe_o[95:64]), 128'(32'hF000_F000));
    wr(a_oe(2), 32'h0000_0000);
    #0.1 chk("R7 all tristate", 128'(pin_oe_o[95:64]), 0);
  endtask

  task automatic t_input();
    logic [W-1:0] v;
    wr(a_dir(3), 32'hFFFF_FFFF);
    @(negedge clk_i);
    pin_in_i[127:96] = 32'h1357_9BDF;
    addr_i = a_ro(3);
    #0.5 chk("R5 zero edges", 128'(rdata_o), 0);
    @(negedge clk_i); #0.5 chk("R5 one edge", 128'(rdata_o), 0);
    @(negedge clk_i); #0.5 chk("R5 two edges", 128'(rdata_o), 128'(32'h1357_9BDF));
    wr(a_ro(3), 32'h0);
    rd(a_ro(3), v); chk("R5 write ignored", 128'(v), 128'(32'h1357_9BDF));
  endtask

  task automatic t_unimpl();
    logic [W-1:0] v;
    wr(a_data(1), 32'hFFFF_FFFF);
    rd(a_data(1), v); chk("R8 data", 128'(v), 128'(IMPL[1]));
    wr(a_dir(1), 32'hFFFF_FFFF);
    wr(a_oe(1), 32'hFFFF_FFFF);
    rd(a_oe(1), v); chk("R8 oe", 128'(v), 128'(IMPL[1]));
    chk("R8 pin_oe", 128'(pin_oe_o[63:32]), 128'(IMPL[1]));
    chk("R8 pin_out", 128'(pin_out_o[63:32]), 128'(IMPL[1]));
    wr(a_mhi(1), {16'h0000, 16'h0000});
    rd(a_data(1), v); chk("R8 masked high", 128'(v), 128'(32'h0000_FFFF));
    @(negedge clk_i); pin_in_i[63:32] = '1;
    repeat (2) @(negedge clk_i);
    rd(a_ro(1), v); chk("R8 input", 128'(v), 128'(IMPL[1]));
  endtask

  task automatic t_undef();
    logic [W-1:0] v;
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h2FC, 32'hFFFF_FFFF);
    rd(a_data(0), v); chk("R9 bank0 kept", 128'(v), 128'(32'hA5A4_1234));
    rd(a_dir(0), v);  chk("R9 dir0 kept", 128'(v), 0);
    rd(12'h020, v); chk("R9 read 0x020", 128'(v), 0);
    rd(12'h200, v); chk("R9 read 0x200", 128'(v), 0);
  endtask

  task automatic t_edge();
    @(negedge clk_i);
    addr_i = a_data(0); wdata_i = 32'h0BAD_F00D; we_i = 1'b1;
    #0.5 chk("R10 old before edge", 128'(rdata_o), 128'(32'hA5A4_1234));
    @(negedge clk_i); we_i = 1'b0;
    #0.5 chk("R10 new after edge", 128'(rdata_o), 128'(32'h0BAD_F00D));
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_data_toggle();
    t_masked();
    t_dir_oe();
    t_input();
    t_unimpl();
    t_undef();
    t_edge();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule